// File: doc/BRIEF.md
# Write-Miss Invalidation Collector

This block sits on the requesting side of a directory-based coherent memory system. It handles one write miss at a time. The home node answers the miss with the block data and a vector of the nodes that hold a copy. The collector takes both in, drops its own node from the vector, and sends an invalidation request to each remaining sharer. It then waits until every one of those sharers has acknowledged.

Invalidations leave through a valid/ready channel, one per accepted handshake, with the lowest-numbered sharer first. Acknowledgements come back tagged with the sender's node number. They may arrive in any order, and they may arrive while later invalidations are still going out. Once no invalidation is left to send and none is left unacknowledged, the block is handed to the local cache for install in the Modified state. An acknowledgement from a node that owes none raises a one-cycle error flag and is otherwise discarded.

Top module: `wm_inval_collector`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `inv_valid`, `fill_valid` and `ack_err` are low.
- R2: A response accepted while idle yields exactly one invalidation for each set bit of `rsp_sharers`, where bit n means node n. Bit `SELF_ID` never yields one.
- R3: Invalidations go out in ascending node number, one per cycle in which `inv_valid` and `inv_ready` are both high.
- R4: While `inv_ready` is low, `inv_valid` stays high and `inv_dest` holds its value.
- R5: `fill_valid` pulses for one cycle, in the cycle after the edge that accepts the last outstanding acknowledgement. It never pulses while an invalidation is unsent or unacknowledged.
- R6: A response whose vector has no bit set other than `SELF_ID` completes at once: `fill_valid` pulses in the cycle after the response, and no invalidation is sent.
- R7: While `fill_valid` is high, `fill_state` is 2'b11 (Modified) and `fill_data` equals the data of the accepted response. While it is low, `fill_state` is 2'b00.
- R8: Acknowledgements for sent invalidations are accepted in any order, including in a cycle that also hands off another invalidation, and they raise no error.
- R9: An acknowledgement whose source has no invalidation outstanding raises `ack_err` for one cycle, in the next cycle, and changes nothing else. This covers a node not yet sent to, a node already acknowledged, and any acknowledgement while idle.
- R10: `rsp_valid` is ignored while a write miss is in progress. It adds no invalidations and does not change the data later delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rsp_valid | input | 1 | Home-node response present this cycle |
| rsp_data | input | DATA_W | Block data from the home node |
| rsp_sharers | input | NODES | Presence vector, bit n for node n |
| inv_valid | output | 1 | Invalidation request available |
| inv_ready | input | 1 | Network accepts the invalidation |
| inv_dest | output | ID_W | Destination node of the invalidation |
| ack_valid | input | 1 | Invalidation acknowledgement present |
| ack_src | input | ID_W | Node that sent the acknowledgement |
| ack_err | output | 1 | Unexpected acknowledgement seen in the previous cycle |
| fill_valid | output | 1 | One-cycle pulse: install the block now |
| fill_state | output | 2 | Line state to install (2'b11 Modified) |
| fill_data | output | DATA_W | Block data to install |

## Verification
The bench runs vectors that hold only the requester's own bit, hold no bits at all, and hold every bit. A design that forgot to mask itself would send an invalidation to its own node and never complete. One that mishandled an empty vector would hang instead of completing at once. Acknowledgements are returned in reverse order, and one of them lands in the same cycle as the next invalidation hand-off. A design that cleared pending bits wrongly, or that finished on the count of acknowledgements rather than on which nodes sent them, would complete early or never. Stray, duplicate and idle acknowledgements, a second response arriving mid-miss, and a stalled network side probe whether a design corrupts its pending set, drops or reorders invalidations, or overwrites the captured data.

// File: rtl/wmic_pkg.sv
package wmic_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } wmic_state_e;

  localparam logic [1:0] LINE_INVALID  = 2'b00;
  localparam logic [1:0] LINE_MODIFIED = 2'b11;
endpackage

// File: rtl/wmic_first_one.sv
module wmic_first_one #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  // Lowest set bit wins: scan from the top so the last hit is the lowest.
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
    any = |vec;
  end
endmodule

// File: rtl/wmic_send_queue.sv
module wmic_send_queue #(
  parameter int NODES = 8,
  parameter int ID_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [NODES-1:0] load_mask,
  input  logic             inv_ready,
  output logic             inv_valid,
  output logic [ID_W-1:0]  inv_dest,
  output logic [NODES-1:0] fire_mask,
  output logic             left_next
);
  logic [NODES-1:0] send_q, send_d;
  logic             any;

  wmic_first_one #(.N(NODES), .IW(ID_W)) enc_i (
    .vec (send_q),
    .idx (inv_dest),
    .any (any)
  );

  assign inv_valid = any;
  // Isolate the lowest set bit of send_q, the one the encoder picks.
  assign fire_mask = (any && inv_ready) ? (send_q & ~(send_q - 1'b1)) : '0;

  always_comb begin
    send_d    = load ? load_mask : (send_q & ~fire_mask);
    left_next = |send_d;
  end

  always_ff @(posedge clk) begin
    if (rst) send_q <= '0;
    else     send_q <= send_d;
  end
endmodule

// File: rtl/wmic_ack_tracker.sv
module wmic_ack_tracker #(
  parameter int NODES = 8,
  parameter int ID_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NODES-1:0] fire_mask,
  input  logic             ack_valid,
  input  logic [ID_W-1:0]  ack_src,
  output logic             ack_err,
  output logic             left_next
);
  logic [NODES-1:0] pend_q, pend_d, ack_mask;
  logic             hit;
  logic             err_q;

  always_comb begin
    ack_mask = '0;
    for (int i = 0; i < NODES; i++) begin
      if (ack_valid && ack_src == ID_W'(i) && pend_q[i]) ack_mask[i] = 1'b1;
    end
    hit       = |ack_mask;
    pend_d    = (pend_q | fire_mask) & ~ack_mask;
    left_next = |pend_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      err_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      err_q  <= ack_valid && !hit;
    end
  end

  assign ack_err = err_q;
endmodule

// File: rtl/wm_inval_collector.sv
module wm_inval_collector
  import wmic_pkg::*;
#(
  parameter int NODES   = 8,
  parameter int SELF_ID = 2,
  parameter int DATA_W  = 16,
  localparam int ID_W   = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic [NODES-1:0]  rsp_sharers,
  output logic              inv_valid,
  input  logic              inv_ready,
  output logic [ID_W-1:0]   inv_dest,
  input  logic              ack_valid,
  input  logic [ID_W-1:0]   ack_src,
  output logic              ack_err,
  output logic              fill_valid,
  output logic [1:0]        fill_state,
  output logic [DATA_W-1:0] fill_data
);
  localparam logic [NODES-1:0] SELF_MASK = {{(NODES-1){1'b0}}, 1'b1} << SELF_ID;

  wmic_state_e       state_q;
  logic [DATA_W-1:0] data_q;
  logic              fill_q;
  logic [1:0]        fstate_q;
  logic [DATA_W-1:0] fdata_q;

  logic              load;
  logic [NODES-1:0]  load_mask;
  logic [NODES-1:0]  fire_mask;
  logic              send_left, pend_left;

  assign load      = (state_q == ST_IDLE) && rsp_valid;
  assign load_mask = rsp_sharers & ~SELF_MASK;

  wmic_send_queue #(.NODES(NODES), .ID_W(ID_W)) sendq_i (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_mask (load_mask),
    .inv_ready (inv_ready),
    .inv_valid (inv_valid),
    .inv_dest  (inv_dest),
    .fire_mask (fire_mask),
    .left_next (send_left)
  );

  wmic_ack_tracker #(.NODES(NODES), .ID_W(ID_W)) ackt_i (
    .clk       (clk),
    .rst       (rst),
    .fire_mask (fire_mask),
    .ack_valid (ack_valid),
    .ack_src   (ack_src),
    .ack_err   (ack_err),
    .left_next (pend_left)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      data_q   <= '0;
      fill_q   <= 1'b0;
      fstate_q <= LINE_INVALID;
      fdata_q  <= '0;
    end else begin
      fill_q   <= 1'b0;
      fstate_q <= LINE_INVALID;
      case (state_q)
        ST_IDLE: begin
          if (rsp_valid) begin
            data_q <= rsp_data;
            if (|load_mask) begin
              state_q <= ST_BUSY;
            end else begin
              fill_q   <= 1'b1;
              fstate_q <= LINE_MODIFIED;
              fdata_q  <= rsp_data;
            end
          end
        end
        ST_BUSY: begin
          if (!send_left && !pend_left) begin
            state_q  <= ST_IDLE;
            fill_q   <= 1'b1;
            fstate_q <= LINE_MODIFIED;
            fdata_q  <= data_q;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign fill_valid = fill_q;
  assign fill_state = fstate_q;
  assign fill_data  = fdata_q;
endmodule

// File: rtl/wmic_checker.sv
module wmic_checker #(
  parameter int NODES   = 8,
  parameter int SELF_ID = 2,
  parameter int ID_W    = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            inv_valid,
  input logic            inv_ready,
  input logic [ID_W-1:0] inv_dest,
  input logic            fill_valid,
  input logic [1:0]      fill_state
);
  // R2: never an invalidation to the requester itself
  assert_no_self_inval_R2: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> (int'(inv_dest) != SELF_ID));

  // R3: destinations strictly ascend within one miss
  assert_ascending_dest_R3: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && inv_ready) |=> (!inv_valid || (inv_dest > $past(inv_dest))));

  // R4: a stalled request holds
  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && !inv_ready) |=> (inv_valid && $stable(inv_dest)));

  // R5: no completion while an invalidation is still waiting to go out
  assert_no_early_fill_R5: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> !inv_valid);

  // R7: install state is Modified exactly when filling
  assert_fill_modified_R7: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> (fill_state == 2'b11));
  assert_idle_state_R7: assert property (@(posedge clk) disable iff (rst)
    !fill_valid |-> (fill_state == 2'b00));
endmodule

bind wm_inval_collector wmic_checker #(
  .NODES(NODES), .SELF_ID(SELF_ID), .ID_W(ID_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .inv_valid  (inv_valid),
  .inv_ready  (inv_ready),
  .inv_dest   (inv_dest),
  .fill_valid (fill_valid),
  .fill_state (fill_state)
);

// File: tb/wm_inval_collector_tb_top.sv
module wm_inval_collector_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NODES = 8;
  localparam int SELF  = 2;
  localparam int DW    = 16;
  localparam int IW    = 3;
  localparam int NVEC  = 6;
  // {presence vector, data}
  localparam logic [23:0] VEC_TBL [NVEC] = '{
    {8'b0000_0100, 16'h1111},
    {8'b0000_0000, 16'h2222},
    {8'b1111_1111, 16'h3333},
    {8'b1000_0001, 16'h4444},
    {8'b0010_1000, 16'h5555},
    {8'b0101_0010, 16'h6666}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic rsp_valid = 0; logic [DW-1:0] rsp_data = '0; logic [NODES-1:0] rsp_sharers = '0;
  logic inv_valid; logic inv_ready = 0; logic [IW-1:0] inv_dest;
  logic ack_valid = 0; logic [IW-1:0] ack_src = '0;
  logic ack_err, fill_valid; logic [1:0] fill_state; logic [DW-1:0] fill_data;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wm_inval_collector #(.NODES(NODES), .SELF_ID(SELF), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_sharers(rsp_sharers), .inv_valid(inv_valid), .inv_ready(inv_ready),
    .inv_dest(inv_dest), .ack_valid(ack_valid), .ack_src(ack_src),
    .ack_err(ack_err), .fill_valid(fill_valid), .fill_state(fill_state),
    .fill_data(fill_data)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_rsp(logic [NODES-1:0] v, logic [DW-1:0] d);
    @(negedge clk); rsp_valid = 1; rsp_sharers = v; rsp_data = d;
    @(negedge clk); rsp_valid = 0;
  endtask

  task automatic ack(int src);
    ack_valid = 1; ack_src = IW'(src);
    @(negedge clk); ack_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int exp_ids [NODES];
    int exp_cnt;
    repeat (3) @(negedge clk);
    check("R1 inv_valid in reset", inv_valid, 0);
    check("R1 fill_valid in reset", fill_valid, 0);
    rst = 0;
    @(negedge clk);
    check("R1 inv_valid after reset", inv_valid, 0);
    check("R1 fill_valid after reset", fill_valid, 0);
    check("R1 ack_err after reset", ack_err, 0);

    // Table walk
    for (int t = 0; t < NVEC; t++) begin
      logic [NODES-1:0] v;
      logic [DW-1:0] d;
      v = VEC_TBL[t][23:16]; d = VEC_TBL[t][15:0];
      exp_cnt = 0;
      for (int n = 0; n < NODES; n++)
        if (v[n] && n != SELF) begin exp_ids[exp_cnt] = n; exp_cnt++; end
      inv_ready = 1;
      send_rsp(v, d);
      if (exp_cnt == 0) begin
        check("R6 empty completes at once", fill_valid, 1);
        check("R7 fill_state", fill_state, 3);
        check("R7 fill_data", fill_data, d);
        check("R6 no invalidation", inv_valid, 0);
        @(negedge clk);
        check("R5 pulse one cycle", fill_valid, 0);
        continue;
      end
      check("R5 no fill before acks", fill_valid, 0);
      for (int k = 0; k < exp_cnt; k++) begin
        check("R2 inv_valid", inv_valid, 1);
        check("R3 ascending dest", inv_dest, exp_ids[k]);
        @(negedge clk);
      end
      check("R2 no extra invalidation", inv_valid, 0);
      inv_ready = 0;
      for (int k = exp_cnt - 1; k >= 0; k--) begin
        ack(exp_ids[k]);
        check("R8 any-order ack no error", ack_err, 0);
        check("R5 fill after last ack", fill_valid, (k == 0) ? 1 : 0);
        if (k == 0) begin
          check("R7 fill_state", fill_state, 3);
          check("R7 fill_data", fill_data, d);
        end
      end
      @(negedge clk);
      check("R5 pulse one cycle", fill_valid, 0);
    end

    // Backpressure: sharer node 6 only
    inv_ready = 0;
    send_rsp(8'b0100_0000, 16'h7777);
    for (int c = 0; c < 3; c++) begin
      check("R4 held valid", inv_valid, 1);
      check("R4 held dest", inv_dest, 6);
      @(negedge clk);
    end
    inv_ready = 1;
    @(negedge clk);
    check("R4 sent once released", inv_valid, 0);
    inv_ready = 0;
    ack(6);
    check("R5 fill after ack", fill_valid, 1);
    check("R7 fill_data", fill_data, 16'h7777);

    // Overlap, stray acks, response while busy: sharers 0 and 4
    inv_ready = 1;
    send_rsp(8'b0001_0001, 16'hAAAA);
    check("R3 first dest", inv_dest, 0);
    @(negedge clk);
    check("R3 second dest", inv_dest, 4);
    rsp_valid = 1; rsp_sharers = 8'hFF; rsp_data = 16'hBBBB;
    ack(0);
    rsp_valid = 0;
    check("R8 ack during send no error", ack_err, 0);
    check("R10 busy response adds nothing", inv_valid, 0);
    check("R5 no fill with ack pending", fill_valid, 0);
    ack(5);
    check("R9 stray ack flagged", ack_err, 1);
    check("R9 stray ack no fill", fill_valid, 0);
    ack(0);
    check("R9 duplicate ack flagged", ack_err, 1);
    check("R9 duplicate ack no fill", fill_valid, 0);
    ack(4);
    check("R9 error lasts one cycle", ack_err, 0);
    check("R5 fill after last ack", fill_valid, 1);
    check("R10 data from first response", fill_data, 16'hAAAA);
    check("R7 fill_state", fill_state, 3);
    ack(1);
    check("R9 idle ack flagged", ack_err, 1);
    check("R9 idle ack no fill", fill_valid, 0);
    check("R9 idle ack no invalidation", inv_valid, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule